// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block is an eight-stage register with a single serial output. On each counted clock it either captures a byte from its parallel inputs or moves every stage one place along, taking a new bit in at the front. It has two clock pins of equal standing. Either pin can serve as the clock while the other acts as a pause control. An asynchronous active-low clear empties the register at any time.

The block runs entirely on one fast free-running system clock, `clk`. The two clock pins are plain logic inputs that `clk` samples through a short synchronizer chain. A clock counts only when the OR of the two synchronized pins goes from high to low. This is the moment the NOR of the pins rises. The register acts in the system cycle in which that fall is seen.

The mode input, the serial input and the parallel inputs are read directly in that cycle. They must stay steady from before the counting pin falls until a few system cycles after it.

Top module: `pload_shift_reg`

## Requirements
- R1: While `clr_n` is low, all eight stages are zero and `ser_out` is 0. This takes effect without waiting for a `clk` edge, and no clock pin, mode or data input changes it.
- R2: The register changes only when the OR of the two clock pins falls from 1 to 0, and it changes exactly once for each such fall. A rise of either pin causes no change.
- R3: With `mode_shift` = 1, a counted clock puts `ser_in` into the first stage and moves each stage's value one place toward the last stage. `ser_out` always shows the last stage, so the first bit shifted in appears at `ser_out` after eight shifts.
- R4: With `mode_shift` = 0, a counted clock loads `par_in[7]` into the first stage and `par_in[0]` into the last stage. `ser_out` therefore shows `par_in[0]` at once, and later shifts present `par_in[1]` through `par_in[7]` in that order.
- R5: During a parallel load, `ser_in` has no effect on any stage.
- R6: While either clock pin is held at 1, toggling the other pin changes nothing.
- R7: The two clock pins are interchangeable. Either one can be the counting clock while the other, held low, enables it or, held high, blocks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock that samples every input |
| clr_n | input | 1 | Asynchronous clear, active low |
| ck_a | input | 1 | Clock pin A, sampled as data |
| ck_b | input | 1 | Clock pin B, sampled as data |
| mode_shift | input | 1 | 1 selects serial shift, 0 selects parallel load |
| ser_in | input | 1 | Serial data into the first stage |
| par_in | input | 8 | Parallel data; bit 7 goes to the first stage, bit 0 to the last |
| ser_out | output | 1 | Value of the last stage |

## Verification
The hardest situation to reach from the ports is a clock pin toggling while its partner holds the register paused. The paused state must survive several full pulses, and the release must then produce exactly one count. The stimulus loads a known byte and raises one pin. It pulses the other pin several times and checks that the output has not moved. It then drops the blocking pin while the counting pin is high, so that the later fall of the counting pin is the only counted edge. A clear dropped between two system edges is checked before the next edge arrives, and the same pause test is repeated with the two pins' roles swapped.

// File: rtl/gsr_pkg.sv
package gsr_pkg;

    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } shift_mode_e;

    localparam int DEF_STAGES = 8;
    localparam int DEF_SYNC   = 2;

endpackage

// File: rtl/gsr_edge_detect.sv
module gsr_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic clr_n,
    input  logic ck_a,
    input  logic ck_b,
    output logic tick
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sa;
        logic [SYNC_STAGES-1:0] sb;
        logic                   or_prev;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic        or_now;

    always_comb begin
        st_d       = st_q;
        st_d.sa    = (st_q.sa << 1) | SYNC_STAGES'(ck_a);
        st_d.sb    = (st_q.sb << 1) | SYNC_STAGES'(ck_b);
        or_now     = st_q.sa[LAST] | st_q.sb[LAST];
        st_d.or_prev = or_now;
        tick       = st_q.or_prev & ~or_now;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!clr_n)
        tick |=> !tick); // R2

endmodule

// File: rtl/gsr_next_stage.sv
module gsr_next_stage #(
    parameter int STAGES = 8
) (
    input  logic                     tick,
    input  gsr_pkg::shift_mode_e     mode,
    input  logic                     ser_in,
    input  logic [STAGES-1:0]        par_in,
    input  logic [STAGES-1:0]        cur,
    output logic [STAGES-1:0]        nxt
);

    for (genvar i = 0; i < STAGES; i++) begin : g_bit
        logic shift_src;
        logic load_src;
        if (i == 0) begin : g_head
            assign shift_src = ser_in;
        end else begin : g_body
            assign shift_src = cur[i-1];
        end
        assign load_src = par_in[STAGES-1-i];
        always_comb begin
            if (!tick) begin
                nxt[i] = cur[i];
            end else if (mode == gsr_pkg::MODE_SHIFT) begin
                nxt[i] = shift_src;
            end else begin
                nxt[i] = load_src;
            end
        end
    end

endmodule

// File: rtl/pload_shift_reg.sv
module pload_shift_reg #(
    parameter int STAGES      = gsr_pkg::DEF_STAGES,
    parameter int SYNC_STAGES = gsr_pkg::DEF_SYNC
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              ck_a,
    input  logic              ck_b,
    input  logic              mode_shift,
    input  logic              ser_in,
    input  logic [STAGES-1:0] par_in,
    output logic              ser_out
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] stg;
    } reg_state_t;

    reg_state_t           st_d, st_q;
    logic                 tick;
    logic [STAGES-1:0]    stg_nxt;
    gsr_pkg::shift_mode_e mode;

    assign mode = gsr_pkg::shift_mode_e'(mode_shift);

    gsr_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .clr_n (clr_n),
        .ck_a  (ck_a),
        .ck_b  (ck_b),
        .tick  (tick)
    );

    gsr_next_stage #(.STAGES(STAGES)) u_next (
        .tick   (tick),
        .mode   (mode),
        .ser_in (ser_in),
        .par_in (par_in),
        .cur    (st_q.stg),
        .nxt    (stg_nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.stg = stg_nxt;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_out = st_q.stg[LAST];

    AST_CLEAR_ZERO: assert property (@(posedge clk)
        !clr_n |-> (st_q.stg == '0 && !ser_out)); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!clr_n)
        !tick |=> $stable(st_q.stg)); // R6

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!clr_n)
        (tick && mode_shift) |=> st_q.stg[0] == $past(ser_in)); // R3

    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!clr_n)
        (tick && mode_shift) |=> st_q.stg[LAST:1] == $past(st_q.stg[LAST-1:0])); // R3

    AST_LOAD_LAST: assert property (@(posedge clk) disable iff (!clr_n)
        (tick && !mode_shift) |=> ser_out == $past(par_in[0])); // R4

    AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!clr_n)
        (tick && !mode_shift) |=> st_q.stg[0] == $past(par_in[LAST])); // R5

endmodule

// File: tb/tb_pload_shift_reg.sv
module tb_pload_shift_reg;

    logic       clk = 1'b0;
    logic       clr_n = 1'b1;
    logic       ck_a = 1'b0;
    logic       ck_b = 1'b0;
    logic       mode_shift = 1'b1;
    logic       ser_in = 1'b0;
    logic [7:0] par_in = 8'h00;
    logic       ser_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pload_shift_reg dut (
        .clk        (clk),
        .clr_n      (clr_n),
        .ck_a       (ck_a),
        .ck_b       (ck_b),
        .mode_shift (mode_shift),
        .ser_in     (ser_in),
        .par_in     (par_in),
        .ser_out    (ser_out)
    );

    // {mode, ser, pin (0=ck_a,1=ck_b), par[7:0], expected ser_out}
    localparam int NV = 14;
    localparam logic [11:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 8'hA5, 1'b1},
        {1'b1, 1'b1, 1'b0, 8'h00, 1'b0},
        {1'b1, 1'b0, 1'b1, 8'h00, 1'b1},
        {1'b1, 1'b1, 1'b0, 8'h00, 1'b0},
        {1'b1, 1'b1, 1'b1, 8'h00, 1'b0},
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b1},
        {1'b1, 1'b0, 1'b1, 8'h00, 1'b0},
        {1'b1, 1'b1, 1'b0, 8'h00, 1'b1},
        {1'b1, 1'b0, 1'b1, 8'h00, 1'b1},
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b0},
        {1'b1, 1'b1, 1'b0, 8'h00, 1'b1},
        {1'b0, 1'b1, 1'b1, 8'h3C, 1'b0},
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b0},
        {1'b1, 1'b0, 1'b1, 8'h00, 1'b1}
    };

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: ser_out=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_pin(input bit sel, input logic v);
        if (sel) ck_b = v; else ck_a = v;
    endtask

    // raise then drop one pin; only the drop may count
    task automatic pulse(input bit sel);
        @(negedge clk);
        set_pin(sel, 1'b1);
        wait_cyc(5);
        set_pin(sel, 1'b0);
        wait_cyc(6);
    endtask

    task automatic load_byte(input logic [7:0] b, input bit sel);
        @(negedge clk);
        mode_shift = 1'b0;
        par_in = b;
        pulse(sel);
        mode_shift = 1'b1;
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: ser_out=%0b expected=finish", ser_out);
            report();
        end
    end

    initial begin
        #1 clr_n = 1'b0;
        wait_cyc(3);
        check(ser_out, 1'b0, "R1 reset state");
        clr_n = 1'b1;
        wait_cyc(3);

        // vector walk: R3 shift, R4/R5 load, R7 both pins
        for (int v = 0; v < NV; v++) begin
            logic [11:0] e;
            e = VEC[v];
            @(negedge clk);
            mode_shift = e[11];
            ser_in = e[10];
            par_in = e[8:1];
            pulse(e[9]);
            check(ser_out, e[0], e[11] ? (e[9] ? "R3/R7 shift via ck_b" : "R3 shift")
                                      : "R4/R5 load");
        end

        // R2: a rising pin alone does nothing; its fall counts once
        load_byte(8'h02, 1'b0);
        check(ser_out, 1'b0, "R4 load 02");
        ser_in = 1'b0;
        @(negedge clk);
        ck_a = 1'b1;
        wait_cyc(6);
        check(ser_out, 1'b0, "R2 rise ignored");
        ck_a = 1'b0;
        wait_cyc(6);
        check(ser_out, 1'b1, "R2 fall counts");

        // R6: ck_b blocks ck_a
        load_byte(8'h01, 1'b0);
        check(ser_out, 1'b1, "R4 load 01");
        @(negedge clk);
        ck_b = 1'b1;
        wait_cyc(4);
        pulse(1'b0);
        pulse(1'b0);
        pulse(1'b0);
        check(ser_out, 1'b1, "R6 ck_b high inhibits");
        @(negedge clk);
        ck_a = 1'b1;
        wait_cyc(4);
        ck_b = 1'b0;
        wait_cyc(6);
        check(ser_out, 1'b1, "R6 release while clock high");
        ck_a = 1'b0;
        wait_cyc(6);
        check(ser_out, 1'b0, "R6 resumes with one shift");

        // R7: roles swapped, ck_a blocks ck_b
        load_byte(8'h01, 1'b1);
        check(ser_out, 1'b1, "R7 load via ck_b");
        @(negedge clk);
        ck_a = 1'b1;
        wait_cyc(4);
        pulse(1'b1);
        pulse(1'b1);
        check(ser_out, 1'b1, "R7 ck_a high inhibits ck_b");
        @(negedge clk);
        ck_a = 1'b0;
        wait_cyc(6);
        check(ser_out, 1'b0, "R7 ck_a fall counts");

        // R1: clear between system edges, overriding pins
        load_byte(8'hFF, 1'b0);
        check(ser_out, 1'b1, "R4 load FF");
        @(posedge clk);
        #3 clr_n = 1'b0;
        #1 check(ser_out, 1'b0, "R1 clear without clock edge");
        ck_a = 1'b1;
        wait_cyc(4);
        ck_a = 1'b0;
        wait_cyc(4);
        check(ser_out, 1'b0, "R1 clear overrides clock pins");
        clr_n = 1'b1;
        wait_cyc(3);
        ser_in = 1'b1;
        pulse(1'b0);
        check(ser_out, 1'b0, "R1 all stages cleared");
        for (int k = 0; k < 6; k++) pulse(1'b1);
        check(ser_out, 1'b0, "R3 seven shifts not yet out");
        pulse(1'b0);
        check(ser_out, 1'b1, "R3 first serial bit after eight shifts");

        done = 1'b1;
        report();
    end

endmodule